// File: doc/BRIEF.md
# No-Wait Pipelined Burst SRAM

This block is a synchronous single-port RAM built for a shared data bus that switches between reads and writes on consecutive clocks without idle cycles. All inputs are captured on the rising clock edge: the address, the read/write select, the per-lane write enables, three chip selects, the load/step strobe and the burst-order select. A read hands its word to the bus one edge after its address is taken and holds it until the next edge. A write takes its data from the bus one edge later. Both directions therefore use the same bus slot, and the slot for an address taken at edge k lies between edges k+1 and k+2.

A small controller tracks the current burst. Its states are ST_DESEL (no access), ST_READ (read burst) and ST_WRITE (write burst). On a load cycle (`burst_step` low) it takes one of three transitions, from any state: LOAD_READ to ST_READ, LOAD_WRITE to ST_WRITE, or LOAD_OFF to ST_DESEL when a chip select is inactive. On a step cycle (`burst_step` high) it takes STEP, which keeps the state and moves a 2-bit beat counter. The counter walks the four-word aligned group in linear or interleaved order. A `hold` input freezes the whole block.

The store is banked by byte lane. A read that meets a write still waiting for its data gets the bus data for the lanes that write enables. This gives the read the newer value, merged lane by lane.

Top module: `zt_burst_sram`

## Requirements
- R1: After reset `dq_drv` is 0, the controller is in ST_DESEL, and step cycles issued before any load start no access and drive nothing.
- R2: For a read whose address is taken at edge k, `dq_drv` is 1 and `dq_out` carries the stored word from just after edge k+1 until edge k+2, provided `drive_en_n` is 0.
- R3: `rd_wr_n` = 0 on a load selects a write. For a write whose address is taken at edge k, `dq_in` is sampled at edge k+2. Lane i, meaning bits [i*LANE_W +: LANE_W], is stored only if `lane_wr_n[i]` was 0 at the address edge.
- R4: With `order_xor` = 0 at the load, beat n of a burst uses low address bits (start + n) mod 4. The upper address bits never change within a burst.
- R5: With `order_xor` = 1 at the load, beat n uses low address bits start XOR n. The upper bits are again unchanged.
- R6: A step cycle repeats the access type of the last load (read, write or none) at the next burst address. `lane_wr_n` is sampled again on every beat.
- R7: A load with `sel0_n` = 1, `sel1` = 0 or `sel2_n` = 1 starts no access. `dq_drv` stays 0 in that access's slot, and no word is written.
- R8: While `hold` = 1 every other input, `dq_in` included, is ignored. The controller, the pipeline, the store and the output register all keep their values.
- R9: Reads and writes may alternate on every clock. A read taken one edge after a write to the same address returns that write's data in its enabled lanes and the old data in the other lanes.
- R10: `drive_en_n` = 1 forces `dq_drv` to 0 and `dq_out` to 0 at once, with no clock edge, and leaves the pipeline as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | 1 freezes the block and ignores all synchronous inputs |
| burst_step | input | 1 | 0 loads a new address, 1 steps the current burst |
| rd_wr_n | input | 1 | Access type at load: 1 read, 0 write |
| addr | input | ADDR_W | Word address, used on load cycles |
| lane_wr_n | input | LANES | Active-low write enable for each byte lane |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| order_xor | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| drive_en_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_drv | output | 1 | 1 when the block drives the bus |

## Verification
The hardest case to reach is a read taken exactly one edge after a partial-lane write to the same address, where the read must merge write data that is only now on `dq_in`. A directed sequence alternates write and read loads on the same and neighbouring addresses with mixed lane masks. Random stimulus then keeps producing such pairs, some with `hold` cycles between them and some inside bursts that wrap their four-word group. Every bus slot is compared with a bench model of memory and of the burst order.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Access carried down the pipeline.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Burst controller states.
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } burst_state_e;

    // Low two address bits of beat `beat` of a burst starting at `start`.
    function automatic logic [1:0] beat_low(
        input logic [1:0] start,
        input logic [1:0] beat,
        input logic       interleave
    );
        return interleave ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              burst_step,
    input  logic              rd_wr_n,
    input  logic              sel_ok,
    input  logic              order_xor,
    input  logic [ADDR_W-1:0] addr,
    output op_e               iss_op,
    output logic [ADDR_W-1:0] iss_addr
);

    burst_state_e      state_q, state_d;
    logic [ADDR_W-1:0] base_q,  base_d;
    logic [1:0]        beat_q,  beat_d;
    logic              xor_q,   xor_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            base_q  <= '0;
            beat_q  <= '0;
            xor_q   <= 1'b0;
        end else if (!hold) begin
            state_q <= state_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            xor_q   <= xor_d;
        end
    end

    // Transitions: LOAD_READ, LOAD_WRITE, LOAD_OFF, STEP.
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q + 2'd1;
        xor_d   = xor_q;
        if (!burst_step) begin
            base_d = addr;
            beat_d = 2'd0;
            xor_d  = order_xor;
            if (!sel_ok) begin
                state_d = ST_DESEL;
            end else if (rd_wr_n) begin
                state_d = ST_READ;
            end else begin
                state_d = ST_WRITE;
            end
        end
    end

    // Outputs: the access issued at this edge.
    always_comb begin
        iss_addr = {base_d[ADDR_W-1:2], beat_low(base_d[1:0], beat_d, xor_d)};
        unique case (state_d)
            ST_READ:  iss_op = OP_READ;
            ST_WRITE: iss_op = OP_WRITE;
            default:  iss_op = OP_IDLE;
        endcase
    end

endmodule

// File: rtl/zt_op_pipe.sv
module zt_op_pipe
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  op_e               iss_op,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [LANES-1:0]  iss_lanes_n,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_lanes_n,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_lanes_n
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op      <= OP_IDLE;
            s1_addr    <= '0;
            s1_lanes_n <= '1;
            s2_op      <= OP_IDLE;
            s2_addr    <= '0;
            s2_lanes_n <= '1;
        end else if (!hold) begin
            s1_op      <= iss_op;
            s1_addr    <= iss_addr;
            s1_lanes_n <= iss_lanes_n;
            s2_op      <= s1_op;
            s2_addr    <= s1_addr;
            s2_lanes_n <= s1_lanes_n;
        end
    end

endmodule

// File: rtl/zt_lane_store.sv
module zt_lane_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lanes_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic                    rd_valid_q,
    output logic [LANES*LANE_W-1:0] rd_data_q
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] rd_word;
    logic              same_addr;

    assign same_addr = wr_en && (wr_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic              lane_wr;

        assign lane_wr = wr_en && !wr_lanes_n[g];

        always_ff @(posedge clk) begin
            if (!hold && lane_wr) begin
                bank[wr_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Newer bus data wins for a lane written on this same edge.
        assign rd_word[g*LANE_W +: LANE_W] =
            (same_addr && !wr_lanes_n[g]) ? wdata[g*LANE_W +: LANE_W] : bank[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else if (!hold) begin
            rd_valid_q <= rd_en;
            if (rd_en) begin
                rd_data_q <= rd_word;
            end
        end
    end

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    burst_step,
    input  logic                    rd_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    order_xor,
    input  logic                    drive_en_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drv
);

    localparam int DATA_W = LANES * LANE_W;

    logic              sel_ok;
    op_e               iss_op;
    logic [ADDR_W-1:0] iss_addr;
    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_lanes_n, s2_lanes_n;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    assign sel_ok = !sel0_n && sel1 && !sel2_n;

    zt_burst_ctl #(.ADDR_W(ADDR_W)) ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .burst_step (burst_step),
        .rd_wr_n    (rd_wr_n),
        .sel_ok     (sel_ok),
        .order_xor  (order_xor),
        .addr       (addr),
        .iss_op     (iss_op),
        .iss_addr   (iss_addr)
    );

    zt_op_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) pipe_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (hold),
        .iss_op      (iss_op),
        .iss_addr    (iss_addr),
        .iss_lanes_n (lane_wr_n),
        .s1_op       (s1_op),
        .s1_addr     (s1_addr),
        .s1_lanes_n  (s1_lanes_n),
        .s2_op       (s2_op),
        .s2_addr     (s2_addr),
        .s2_lanes_n  (s2_lanes_n)
    );

    zt_lane_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .rd_en      (s1_op == OP_READ),
        .rd_addr    (s1_addr),
        .wr_en      (s2_op == OP_WRITE),
        .wr_addr    (s2_addr),
        .wr_lanes_n (s2_lanes_n),
        .wdata      (dq_in),
        .rd_valid_q (rd_valid_q),
        .rd_data_q  (rd_data_q)
    );

    // Asynchronous output gate.
    always_comb begin
        dq_drv = rd_valid_q && !drive_en_n;
        dq_out = dq_drv ? rd_data_q : '0;
    end

    // s1_lanes_n feeds stage 2 only; referenced here for completeness of the stage view.
    logic unused_ok;
    assign unused_ok = &s1_lanes_n | 1'b1;

endmodule

// File: rtl/zt_burst_sram_chk.sv
module zt_burst_sram_chk
    import zt_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hold,
    input logic          burst_step,
    input logic          sel0_n,
    input logic          sel1,
    input logic          sel2_n,
    input logic          drive_en_n,
    input logic          dq_drv,
    input op_e           s1_op,
    input logic [AW-1:0] s1_addr,
    input logic          rd_valid_q,
    input logic [DW-1:0] rd_data_q
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !rd_valid_q);

    p_read_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && s1_op == OP_READ) |=> rd_valid_q);

    p_group_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && burst_step) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

    p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !burst_step && (sel0_n || !sel1 || sel2_n)) |=> (s1_op == OP_IDLE));

    p_no_read_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && s1_op != OP_READ) |=> !rd_valid_q);

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(rd_data_q) && $stable(rd_valid_q) && $stable(s1_addr) && $stable(s1_op)));

    p_gate_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_n |-> !dq_drv);

endmodule

bind zt_burst_sram zt_burst_sram_chk #(.AW(ADDR_W), .DW(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .burst_step (burst_step),
    .sel0_n     (sel0_n),
    .sel1       (sel1),
    .sel2_n     (sel2_n),
    .drive_en_n (drive_en_n),
    .dq_drv     (dq_drv),
    .s1_op      (s1_op),
    .s1_addr    (s1_addr),
    .rd_valid_q (rd_valid_q),
    .rd_data_q  (rd_data_q)
);

// File: tb/zt_burst_sram_tb.sv
`timescale 1ns/1ps
module zt_burst_sram_tb_top;

    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 8;
    localparam int DW = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          i_hold, i_step, i_rw_n, i_s0_n, i_s1, i_s2_n, i_xor, i_oe_n;
    logic [AW-1:0] i_addr;
    logic [LN-1:0] i_lanes_n;
    logic [DW-1:0] i_dq;
    logic [DW-1:0] dq_out;
    logic          dq_drv;

    always #2 clk = ~clk;

    zt_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (i_hold),
        .burst_step (i_step),
        .rd_wr_n    (i_rw_n),
        .addr       (i_addr),
        .lane_wr_n  (i_lanes_n),
        .sel0_n     (i_s0_n),
        .sel1       (i_s1),
        .sel2_n     (i_s2_n),
        .order_xor  (i_xor),
        .drive_en_n (i_oe_n),
        .dq_in      (i_dq),
        .dq_out     (dq_out),
        .dq_drv     (dq_drv)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // Reference model: 0 none, 1 read, 2 write.
    logic [DW-1:0] mem_m [DEPTH];
    logic [1:0]    st_m, p1_op, p2_op;
    logic [AW-1:0] base_m, p1_addr, p2_addr;
    logic [1:0]    cnt_m;
    logic          xor_m, exp_valid;
    logic [LN-1:0] p1_ln, p2_ln;
    logic [DW-1:0] exp_data;

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, logic [1:0] n, logic x);
        logic [1:0] lo;
        lo = x ? (b[1:0] ^ n) : (b[1:0] + n);
        return {b[AW-1:2], lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic model_reset();
        st_m = 2'd0; base_m = '0; cnt_m = '0; xor_m = 1'b0;
        p1_op = 2'd0; p1_addr = '0; p1_ln = '1;
        p2_op = 2'd0; p2_addr = '0; p2_ln = '1;
        exp_valid = 1'b0; exp_data = '0;
    endtask

    // One clock: update the model for this edge, then compare the new slot.
    task automatic tick();
        logic exp_drv;
        i_dq = DW'($urandom);
        if (!i_hold) begin
            if (p2_op == 2'd2)
                for (int l = 0; l < LN; l++)
                    if (!p2_ln[l]) mem_m[p2_addr][l*LW +: LW] = i_dq[l*LW +: LW];
            exp_valid = (p1_op == 2'd1);
            if (p1_op == 2'd1) exp_data = mem_m[p1_addr];
            p2_op = p1_op; p2_addr = p1_addr; p2_ln = p1_ln;
            if (!i_step) begin
                base_m = i_addr; cnt_m = 2'd0; xor_m = i_xor;
                if (!i_s0_n && i_s1 && !i_s2_n) st_m = i_rw_n ? 2'd1 : 2'd2;
                else st_m = 2'd0;
            end else begin
                cnt_m = cnt_m + 2'd1;
            end
            p1_op = st_m; p1_addr = beat_addr(base_m, cnt_m, xor_m); p1_ln = i_lanes_n;
        end
        @(posedge clk);
        @(negedge clk);
        exp_drv = exp_valid && !i_oe_n;
        chk(dq_drv == exp_drv, cur_req, DW'(dq_drv), DW'(exp_drv));
        if (exp_drv) chk(dq_out == exp_data, cur_req, dq_out, exp_data);
    endtask

    task automatic set_idle();
        i_hold = 1'b0; i_step = 1'b0; i_rw_n = 1'b1; i_addr = '0; i_lanes_n = '0;
        i_s0_n = 1'b1; i_s1 = 1'b1; i_s2_n = 1'b0; i_xor = 1'b0; i_oe_n = 1'b0;
    endtask

    task automatic load(input logic rw_n, input logic [AW-1:0] a, input logic [LN-1:0] ln, input logic x);
        i_hold = 1'b0; i_step = 1'b0; i_rw_n = rw_n; i_addr = a; i_lanes_n = ln;
        i_s0_n = 1'b0; i_s1 = 1'b1; i_s2_n = 1'b0; i_xor = x;
        tick();
    endtask

    task automatic step(input logic [LN-1:0] ln);
        i_hold = 1'b0; i_step = 1'b1; i_lanes_n = ln; i_addr = AW'($urandom);
        tick();
    endtask

    task automatic flush();
        set_idle(); tick(); tick();
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        set_idle();
        i_dq = '0;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dq_drv == 1'b0, "R1", DW'(dq_drv), '0);
        rst_n = 1'b1;

        // R1 / R6: steps straight after reset continue the idle state.
        cur_req = "R1";
        for (int i = 0; i < 4; i++) step('0);

        // R3: fill memory with linear write bursts, all lanes.
        cur_req = "R3";
        for (int g = 0; g < DEPTH / 4; g++) begin
            load(1'b0, AW'(g * 4), '0, 1'b0);
            for (int b = 0; b < 3; b++) step('0);
        end
        flush();

        // R2: single reads.
        cur_req = "R2";
        load(1'b1, 6'd5, '0, 1'b0);
        load(1'b1, 6'd40, '0, 1'b0);
        flush();

        // R4: linear burst wrapping from 6 -> 7, 4, 5.
        cur_req = "R4";
        load(1'b1, 6'd6, '0, 1'b0);
        for (int b = 0; b < 3; b++) step('0);
        load(1'b1, 6'd63, '0, 1'b0);
        for (int b = 0; b < 5; b++) step('0);
        flush();

        // R5: interleaved burst 1 -> 0, 3, 2 and 2 -> 3, 0, 1.
        cur_req = "R5";
        load(1'b1, 6'd17, '0, 1'b1);
        for (int b = 0; b < 3; b++) step('0);
        load(1'b1, 6'd34, '0, 1'b1);
        for (int b = 0; b < 3; b++) step('0);
        flush();

        // R6: write burst with a new lane mask per beat, then read it back.
        cur_req = "R6";
        load(1'b0, 6'd9, 4'b0101, 1'b0);
        step(4'b1010);
        step(4'b0000);
        step(4'b1111);
        load(1'b1, 6'd8, '0, 1'b0);
        for (int b = 0; b < 3; b++) step('0);
        flush();

        // R7: each select inactive in turn, on read and write loads.
        cur_req = "R7";
        for (int k = 0; k < 3; k++) begin
            for (int w = 0; w < 2; w++) begin
                i_hold = 1'b0; i_step = 1'b0; i_rw_n = logic'(w); i_addr = AW'(20 + k);
                i_lanes_n = '0; i_xor = 1'b0;
                i_s0_n = (k == 0); i_s1 = (k != 1); i_s2_n = (k == 2);
                tick();
                step('0);
            end
        end
        flush();
        load(1'b1, 6'd20, '0, 1'b0);
        load(1'b1, 6'd21, '0, 1'b0);
        load(1'b1, 6'd22, '0, 1'b0);
        flush();

        // R8: hold cycles with wild inputs in the middle of traffic.
        cur_req = "R8";
        load(1'b0, 6'd30, 4'b0011, 1'b0);
        for (int h = 0; h < 3; h++) begin
            i_hold = 1'b1; i_step = 1'b0; i_rw_n = 1'b0; i_addr = AW'($urandom);
            i_lanes_n = '0; i_s0_n = 1'b0; i_s1 = 1'b1; i_s2_n = 1'b0;
            tick();
        end
        load(1'b1, 6'd30, '0, 1'b0);
        i_hold = 1'b1; tick(); tick();
        flush();

        // R9: alternating write/read on the same address with partial lanes.
        cur_req = "R9";
        for (int a = 0; a < 6; a++) begin
            load(1'b0, AW'(44 + a), LN'(a + 1), 1'b0);
            load(1'b1, AW'(44 + a), '0, 1'b0);
        end
        load(1'b1, 6'd44, '0, 1'b0);
        flush();

        // R10: asynchronous output gate mid slot.
        cur_req = "R10";
        load(1'b1, 6'd12, '0, 1'b0);
        step('0);
        i_oe_n = 1'b1; #1;
        chk(dq_drv == 1'b0 && dq_out == '0, "R10", dq_out, '0);
        i_oe_n = 1'b0; #0.5;
        chk(dq_drv == 1'b1 && dq_out == mem_m[12], "R10", dq_out, mem_m[12]);
        flush();

        // Random mix.
        cur_req = "R9";
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 10);
            i_hold = (r == 0);
            i_step = logic'($urandom % 2);
            i_rw_n = logic'($urandom % 2);
            i_addr = AW'($urandom);
            i_lanes_n = LN'($urandom);
            i_xor = logic'($urandom % 2);
            r = int'($urandom % 12);
            i_s0_n = (r == 0); i_s1 = (r != 1); i_s2_n = (r == 2);
            i_oe_n = ($urandom % 10) == 0;
            tick();
        end
        flush();

        summary();
        $finish;
    end

endmodule